// File: doc/BRIEF.md
# Phase-Frequency Detector with Delayed Clear

This block is a sampled-time model of the phase-frequency detector at the front of a charge-pump phase-locked loop. It runs on a fast system clock. Two inputs, a reference clock and a feedback clock, are assumed synchronous to that system clock. Two pulse outputs, `up` (speed the oscillator up) and `dn` (slow it down), carry the phase error as a pulse width counted in system-clock cycles.

Only rising edges matter. A reference edge raises `up` and a feedback edge raises `dn`. Once both are high, a clear is held off for `CLR_DELAY` cycles and then drops both outputs on the same edge. Every correction therefore lasts at least `CLR_DELAY` cycles, so the loop still responds when the phase error is close to zero. The difference between the two pulse widths equals the distance between the two input edges.

Top module: `pfd_delayed_clear`

## Requirements
- R1: Only rising edges act. An input that stays high or low, or that has any duty cycle, causes no output activity beyond what its rising edges cause.
- R2: A reference rising edge raises `up` on the clock edge where the high input is first sampled. A feedback rising edge raises `dn` in the same way. Each output then stays high until a clear.
- R3: The state reads as `{dn, up}`: 2'b00 means no change, 2'b01 means speed up, 2'b10 means slow down, and 2'b11 is the overlap before the clear.
- R4: Once both outputs are high, they stay high for exactly `CLR_DELAY` cycles. Both then fall on the same clock edge.
- R5: If one input rises `d` cycles before the other, the leading input's output is high for `d + CLR_DELAY` cycles and the other output for `CLR_DELAY` cycles.
- R6: If both inputs rise in the same cycle, both outputs are high for exactly `CLR_DELAY` cycles.
- R7: A rising edge that arrives during the overlap is remembered. Its output is high again on the cycle the clear completes.
- R8: The synchronous active-high reset `rst` drives both outputs low and restarts the clear-delay count. A later simultaneous edge pair then gives a full `CLR_DELAY` overlap.
- R9: An output never falls unless the other output was high in the previous cycle. A second edge on the same input while its output is already high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, sampled on clk |
| fb_in | input | 1 | Feedback clock, sampled on clk |
| up | output | 1 | Speed-up pulse |
| dn | output | 1 | Slow-down pulse |

## Verification
The hardest case to reach is an edge that lands inside the overlap window. It requires one input to rise, fall and rise again within the few cycles between the second output going high and the clear. The stimulus does this by placing the reference edge one cycle before the feedback edge, dropping the reference for one cycle, and raising it again while the clear count is still running. The bench then checks that `up` is already high on the cycle the clear completes, and that the following feedback edge measures its phase lead from that point.

// File: rtl/pfd_delayed_clear.sv
module pfd_delayed_clear #(
  parameter int CLR_DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic up,
  output logic dn
);
  localparam int CW = (CLR_DELAY < 2) ? 1 : $clog2(CLR_DELAY);
  localparam logic [CW-1:0] LAST = CW'(CLR_DELAY - 1);

  logic ref_q, fb_q, hold_up, hold_dn;
  logic [CW-1:0] cnt;

  wire ref_rise = ref_in & ~ref_q;
  wire fb_rise  = fb_in & ~fb_q;
  wire both     = up & dn;
  wire fire     = both && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= 1'b0;
      fb_q    <= 1'b0;
      up      <= 1'b0;
      dn      <= 1'b0;
      hold_up <= 1'b0;
      hold_dn <= 1'b0;
      cnt     <= '0;
    end else begin
      ref_q <= ref_in;
      fb_q  <= fb_in;
      if (fire) begin
        up      <= hold_up | ref_rise;
        dn      <= hold_dn | fb_rise;
        hold_up <= 1'b0;
        hold_dn <= 1'b0;
        cnt     <= '0;
      end else begin
        up <= up | ref_rise;
        dn <= dn | fb_rise;
        if (both) begin
          hold_up <= hold_up | ref_rise;
          hold_dn <= hold_dn | fb_rise;
          cnt     <= cnt + 1'b1;
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  assert_reset_clears_R8: assert property (@(posedge clk) rst |=> (!up && !dn));
  assert_ref_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (ref_in && !ref_q) |=> up);
  assert_fb_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (fb_in && !fb_q) |=> dn);
  assert_level_inert_R1: assert property (@(posedge clk) disable iff (rst)
    (!up && !(ref_in && !ref_q)) |=> !up);
  assert_overlap_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (both && cnt != LAST) |=> (up && dn));
  assert_up_falls_with_dn_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(up) |-> $past(dn));
  assert_dn_falls_with_up_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(dn) |-> $past(up));
  assert_window_edge_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && hold_up) |=> up);
endmodule

// File: tb/sim_pfd_delayed_clear.sv
module sim_pfd_delayed_clear;
  localparam int D = 3;
  logic clk = 1'b0, rst = 1'b1, ref_in = 1'b0, fb_in = 1'b0;
  logic up, dn;
  int n_chk = 0, n_fail = 0;
  int exp_u[$], exp_d[$];
  string exp_tag[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfd_delayed_clear #(.CLR_DELAY(D)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .up(up), .dn(dn));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic f);
    @(negedge clk);
    ref_in = r;
    fb_in  = f;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
  endtask

  task automatic expect_pair(input int wu, input int wd, input string tag);
    exp_u.push_back(wu);
    exp_d.push_back(wd);
    exp_tag.push_back(tag);
  endtask

  // leading input rises d cycles before the other; both then held high
  task automatic lead(input bit ref_first, input int d, input string tag);
    if (ref_first) expect_pair(d + D, D, tag);
    else           expect_pair(D, d + D, tag);
    for (int i = 0; i < d; i++) cyc(ref_first, !ref_first);
    for (int i = 0; i < d + D + 4; i++) cyc(1'b1, 1'b1);
    @(posedge clk); #1;
    check(!up && !dn, "R1 level held high", {dn, up}, 0);
    idle(6);
  endtask

  // monitor: measures each overlap episode and compares with the queue
  int uc = 0, dc = 0;
  bit prevb = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst) begin
      uc = 0; dc = 0; prevb = 1'b0;
    end else begin
      if (prevb && !(up && dn)) begin
        if (exp_u.size() == 0) begin
          check(1'b0, "R4 unexpected clear", 1, 0);
        end else begin
          int eu, ed;
          string t;
          eu = exp_u.pop_front();
          ed = exp_d.pop_front();
          t  = exp_tag.pop_front();
          check(uc == eu, {t, " up width"}, uc, eu);
          check(dc == ed, {t, " dn width"}, dc, ed);
        end
        uc = int'(up);
        dc = int'(dn);
      end else begin
        uc += int'(up);
        dc += int'(dn);
      end
      prevb = up && dn;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!up && !dn, "R8 reset state", {dn, up}, 0);
    cyc(1'b0, 1'b0);
    rst = 1'b0;
    idle(3);
    @(posedge clk); #1;
    check(!up && !dn, "R3 idle 00", {dn, up}, 0);

    // R3 speed-up encoding, then full pulse
    expect_pair(4 + D, D, "R5 ref lead 4");
    cyc(1'b1, 1'b0);
    @(posedge clk); #1;
    check({dn, up} == 2'b01, "R3 code 01", {dn, up}, 1);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1);
    idle(6);

    // R3 slow-down encoding
    expect_pair(D, 2 + D, "R5 fb lead 2");
    cyc(1'b0, 1'b1);
    @(posedge clk); #1;
    check({dn, up} == 2'b10, "R3 code 10", {dn, up}, 2);
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    @(posedge clk); #1;
    check({dn, up} == 2'b11, "R3 code 11", {dn, up}, 3);
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1);
    idle(6);

    lead(1'b1, 1, "R5 ref lead 1");
    lead(1'b0, 5, "R5 fb lead 5");
    lead(1'b1, 0, "R6 same cycle");
    lead(1'b0, 0, "R4 same cycle again");

    // R1: short reference pulse, long feedback pulse; same widths as level case
    expect_pair(3 + D, D, "R1 duty cycle");
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    for (int i = 0; i < 14; i++) cyc(1'b0, 1'b1);
    idle(6);

    // R9: second reference edge while up already high has no effect
    expect_pair(6 + D, D, "R9 repeat edge");
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1);
    idle(6);

    // R7: reference edge inside the overlap window is kept
    expect_pair(1 + D, D, "R7 first episode");
    expect_pair(2 + D, D, "R7 kept edge");
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    @(posedge clk); #1;
    check({dn, up} == 2'b01, "R7 up re-set at clear", {dn, up}, 1);
    cyc(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1);
    idle(6);

    // R8: reset during overlap, then a full overlap afterwards
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
    @(posedge clk); #1;
    check(!up && !dn, "R8 reset mid overlap", {dn, up}, 0);
    @(negedge clk);
    rst = 1'b0;
    idle(3);
    lead(1'b1, 0, "R8 count restarted");

    idle(10);
    check(exp_u.size() == 0, "R4 all episodes seen", exp_u.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "R4 watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule